// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a leaf page-table entry by walking a fixed-depth radix page table held in memory. A requester presents a virtual address together with the current translation-enable flag, the page-table root address and the size of physical memory. The walker answers with a single-cycle completion pulse and a 64-bit entry. An entry of zero means the translation faulted. A TLB or permission stage would sit after it and consume the answer.

With translation off, the walker makes an identity entry for any address inside physical memory, with every permission bit set, and reads nothing from memory. With translation on, it reads one entry per level through a valid/ready read port and keeps at most one read in flight. At each level it either stops on a leaf, descends through a table pointer, or gives up. A leaf found above the bottom level maps a large region. It is rewritten as the equivalent page-sized leaf by merging the untranslated low page-number bits into its frame number. Every entry address and every final physical address is checked against the memory size.

Entry layout used throughout: bit 0 marks a leaf, bit 1 marks a pointer to the next table, bits 7:2 are the six permission bits, and bits 63:13 hold the frame number. Pages are 8 KiB. Each level resolves 10 virtual-address bits, and there are three levels, so the top level uses virtual bits 42:33, the middle level bits 32:23 and the bottom level bits 22:13.

Top module: `pt_walker`

## Requirements
- R1: After reset, `done` and `rd_req_valid` are low and `req_ready` is high.
- R2: With `vm_en` low and the address below `mem_size`, the result is the address with bits 12:0 cleared, OR 0xFC (all six permission bits), OR 1 (leaf bit). `done` rises one cycle after acceptance and no memory read is issued.
- R3: With `vm_en` low and the address at or above `mem_size`, the result is zero.
- R4: Level k (0 = top) reads entry address base + 8 × index, where index is the 10 virtual bits starting at bit 13 + 10 × (2 − k). The base of level 0 is `ptbr`.
- R5: If an entry address is at or above `mem_size`, the walk ends with a zero result and that read is not issued.
- R6: An entry with bit 0 set is a leaf. The walk stops, and the low 10 × (2 − k) virtual page-number bits (virtual address shifted right by 13) are ORed into the frame field at bit 13.
- R7: A leaf is returned only when (frame << 13) + (virtual address bits 12:0) is below `mem_size`. Otherwise the result is zero.
- R8: An entry with bit 0 clear and bit 1 set sets the next level's base to the entry with bits 12:0 cleared.
- R9: An entry with bits 0 and 1 both clear ends the walk with a zero result.
- R10: A table pointer found at the bottom level ends the walk with a zero result.
- R11: The read request holds its address until it is accepted, and no new read starts while a response is pending. Each level produces exactly one read.
- R12: `req_ready` is low from acceptance until the result has been delivered. `vm_en`, `ptbr` and `mem_size` are taken only at acceptance.
- R13: `done` is high for exactly one cycle per request, and a non-zero result always has bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 64 | Virtual address to translate |
| vm_en | input | 1 | Translation enabled |
| ptbr | input | 64 | Root page-table address |
| mem_size | input | 64 | Physical memory size in bytes |
| rd_req_valid | output | 1 | Entry read request |
| rd_req_ready | input | 1 | Memory accepts the read |
| rd_req_addr | output | 64 | Byte address of the entry to read |
| rd_rsp_valid | input | 1 | Read data present |
| rd_rsp_ready | output | 1 | Walker waiting for read data |
| rd_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Leaf entry, or zero on fault |

## Verification
A wrong level counter or base register shows up on the next read request. The read address leaves the expected table offset one cycle after the previous response is taken, so the bench logs and compares every read address, not only the final entry. A wrong shift amount in the large-page rewrite changes only the frame bits of the result on the completion pulse, so the large-page cases use non-zero low index bits. A missed bound shows either as an extra read or as a leaf where zero is expected. Both are visible at completion, within four cycles per level.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WAIT
  } walk_st_t;

  localparam int LEAF_BIT  = 0;
  localparam int TABLE_BIT = 1;
  localparam int PERM_LO   = 2;
  localparam int PERM_HI   = 7;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int XLEN     = 64,
  parameter int LEVELS   = 3,
  parameter int IDXW     = 10,
  parameter int PG_SHIFT = 13,
  parameter int LVL_W    = 2,
  parameter int SH_W     = 5
) (
  input  logic [XLEN-1:0]  base,
  input  logic [XLEN-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  output logic [XLEN-1:0]  pte_addr,
  output logic [SH_W-1:0]  lvl_shift
);
  localparam int ENT_LOG = $clog2(XLEN / 8);

  logic [IDXW-1:0] idx_lv [LEVELS];
  logic [IDXW-1:0] idx_sel;

  // one index slice per level, top level first
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_lv[g] = vaddr[PG_SHIFT + (LEVELS-1-g)*IDXW +: IDXW];
  end

  always_comb begin
    idx_sel   = '0;
    lvl_shift = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) begin
        idx_sel   = idx_lv[i];
        lvl_shift = SH_W'((LEVELS-1-i)*IDXW);
      end
    end
  end

  assign pte_addr = base + (XLEN'(idx_sel) << ENT_LOG);
endmodule

// File: rtl/pw_leaf_fix.sv
module pw_leaf_fix #(
  parameter int XLEN      = 64,
  parameter int PG_SHIFT  = 13,
  parameter int PPN_SHIFT = 13,
  parameter int SH_W      = 5
) (
  input  logic [XLEN-1:0] pte,
  input  logic [XLEN-1:0] vaddr,
  input  logic [SH_W-1:0] lvl_shift,
  input  logic [XLEN-1:0] mem_size,
  output logic [XLEN-1:0] fixed_pte,
  output logic            in_bounds
);
  localparam logic [XLEN-1:0] PG_MASK = (XLEN'(1) << PG_SHIFT) - XLEN'(1);

  logic [XLEN-1:0] low_mask;
  logic [XLEN-1:0] vpn_low;
  logic [XLEN-1:0] phys;

  always_comb begin
    low_mask  = (XLEN'(1) << lvl_shift) - XLEN'(1);
    vpn_low   = (vaddr >> PG_SHIFT) & low_mask;
    fixed_pte = pte | (vpn_low << PPN_SHIFT);
    phys      = ((fixed_pte >> PPN_SHIFT) << PG_SHIFT) + (vaddr & PG_MASK);
    in_bounds = phys < mem_size;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int XLEN      = 64,
  parameter int LEVELS    = 3,
  parameter int IDXW      = 10,
  parameter int PG_SHIFT  = 13,
  parameter int PPN_SHIFT = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XLEN-1:0] req_vaddr,
  input  logic            vm_en,
  input  logic [XLEN-1:0] ptbr,
  input  logic [XLEN-1:0] mem_size,
  output logic            rd_req_valid,
  input  logic            rd_req_ready,
  output logic [XLEN-1:0] rd_req_addr,
  input  logic            rd_rsp_valid,
  output logic            rd_rsp_ready,
  input  logic [XLEN-1:0] rd_rsp_data,
  output logic            done,
  output logic [XLEN-1:0] result
);
  import pw_pkg::*;

  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int SH_W  = $clog2((LEVELS-1)*IDXW + 1) + 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);
  localparam logic [XLEN-1:0] PERM_ALL =
    ((XLEN'(1) << (PERM_HI+1)) - XLEN'(1)) & ~((XLEN'(1) << PERM_LO) - XLEN'(1));
  localparam logic [XLEN-1:0] LEAF_MSK = XLEN'(1) << LEAF_BIT;

  walk_st_t         state;
  logic [XLEN-1:0]  vaddr_q;
  logic [XLEN-1:0]  msize_q;
  logic [XLEN-1:0]  base_q;
  logic [LVL_W-1:0] level_q;
  logic [XLEN-1:0]  rd_addr_q;
  logic             done_q;
  logic [XLEN-1:0]  result_q;

  logic [XLEN-1:0]  pte_addr;
  logic [SH_W-1:0]  lvl_shift;
  logic [XLEN-1:0]  fixed_pte;
  logic             leaf_ok;
  logic [XLEN-1:0]  ident_pte;
  logic             accept;

  pw_addr_gen #(
    .XLEN(XLEN), .LEVELS(LEVELS), .IDXW(IDXW),
    .PG_SHIFT(PG_SHIFT), .LVL_W(LVL_W), .SH_W(SH_W)
  ) u_addr_gen (
    .base(base_q),
    .vaddr(vaddr_q),
    .level(level_q),
    .pte_addr(pte_addr),
    .lvl_shift(lvl_shift)
  );

  pw_leaf_fix #(
    .XLEN(XLEN), .PG_SHIFT(PG_SHIFT), .PPN_SHIFT(PPN_SHIFT), .SH_W(SH_W)
  ) u_leaf_fix (
    .pte(rd_rsp_data),
    .vaddr(vaddr_q),
    .lvl_shift(lvl_shift),
    .mem_size(msize_q),
    .fixed_pte(fixed_pte),
    .in_bounds(leaf_ok)
  );

  assign ident_pte = ((req_vaddr >> PG_SHIFT) << PPN_SHIFT) | PERM_ALL | LEAF_MSK;
  assign req_ready = (state == ST_IDLE) && !done_q;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      vaddr_q   <= '0;
      msize_q   <= '0;
      base_q    <= '0;
      level_q   <= '0;
      rd_addr_q <= '0;
      done_q    <= 1'b0;
      result_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            vaddr_q <= req_vaddr;
            msize_q <= mem_size;
            base_q  <= ptbr;
            level_q <= '0;
            if (!vm_en) begin
              done_q   <= 1'b1;
              result_q <= (req_vaddr < mem_size) ? ident_pte : '0;
            end else begin
              state <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (pte_addr >= msize_q) begin
            done_q   <= 1'b1;
            result_q <= '0;
            state    <= ST_IDLE;
          end else begin
            rd_addr_q <= pte_addr;
            state     <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rd_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_rsp_valid) begin
            if (rd_rsp_data[LEAF_BIT]) begin
              done_q   <= 1'b1;
              result_q <= leaf_ok ? fixed_pte : '0;
              state    <= ST_IDLE;
            end else if (rd_rsp_data[TABLE_BIT] && (level_q != LAST_LVL)) begin
              base_q  <= (rd_rsp_data >> PPN_SHIFT) << PG_SHIFT;
              level_q <= level_q + LVL_W'(1);
              state   <= ST_CHECK;
            end else begin
              done_q   <= 1'b1;
              result_q <= '0;
              state    <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (state == ST_REQ);
  assign rd_req_addr  = rd_addr_q;
  assign rd_rsp_ready = (state == ST_WAIT);
  assign done         = done_q;
  assign result       = result_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R11
  one_out_chk: assert property (@(posedge clk) disable iff (rst)
    rd_rsp_valid && rd_rsp_ready |-> !rd_req_valid);

  // R5
  addr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> rd_req_addr < msize_q);

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R13
  leaf_mark_chk: assert property (@(posedge clk) disable iff (rst)
    done && (result != '0) |-> result[LEAF_BIT]);
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic        vm_en = 1'b0;
  logic [63:0] ptbr = '0;
  logic [63:0] mem_size = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b1;
  logic [63:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic        rd_rsp_ready;
  logic [63:0] rd_rsp_data = '0;
  logic        done;
  logic [63:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] mem_img [logic [63:0]];
  logic [63:0] rd_log [16];
  int          n_reads = 0;
  int          stall_left = 0;
  bit          pend = 0;
  logic [63:0] pend_addr = '0;
  int          last_lat = 0;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .vm_en(vm_en), .ptbr(ptbr), .mem_size(mem_size),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .done(done), .result(result)
  );

  // memory model, driven on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rd_rsp_valid) rd_rsp_valid = 1'b0;
      if (pend) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem_img.exists(pend_addr) ? mem_img[pend_addr] : 64'h0;
        pend = 0;
      end
      if (rd_req_valid && stall_left > 0) begin
        rd_req_ready = 1'b0;
        stall_left--;
      end else begin
        rd_req_ready = 1'b1;
      end
      if (rd_req_valid && rd_req_ready) begin
        pend      = 1;
        pend_addr = rd_req_addr;
        if (n_reads < 16) rd_log[n_reads] = rd_req_addr;
        n_reads++;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_walk(input string req, input logic [63:0] va, input logic vm,
                          input logic [63:0] pt, input logic [63:0] ms,
                          input logic [63:0] exp, input int exp_reads, input bit disturb);
    int lat;
    n_reads   = 0;
    req_vaddr = va;
    vm_en     = vm;
    ptbr      = pt;
    mem_size  = ms;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      if (disturb) begin
        vm_en    = ~vm;
        ptbr     = ~pt;
        mem_size = 64'h0;
        chk("R12 req_ready low while busy", {63'h0, req_ready}, 64'h0);
      end
      @(negedge clk);
      lat++;
    end
    last_lat = lat;
    chk({req, " done seen"}, {63'h0, done}, 64'h1);
    chk({req, " result"}, result, exp);
    chk({req, " read count"}, 64'(n_reads), 64'(exp_reads));
    @(negedge clk);
    chk("R13 done is one cycle", {63'h0, done}, 64'h0);
    vm_en    = vm;
    ptbr     = pt;
    mem_size = ms;
  endtask

  // three-level tree used by several scenarios
  task automatic load_tree(input logic [63:0] leaf);
    mem_img.delete();
    mem_img[64'h2008] = 64'h4002;
    mem_img[64'h4010] = 64'h6002;
    mem_img[64'h6018] = leaf;
  endtask

  localparam logic [63:0] VA_DEEP = 64'h2_0100_6055;

  task automatic t_reset;
    chk("R1 done after reset", {63'h0, done}, 64'h0);
    chk("R1 rd_req_valid after reset", {63'h0, rd_req_valid}, 64'h0);
    chk("R1 req_ready after reset", {63'h0, req_ready}, 64'h1);
  endtask

  task automatic t_vm_off;
    mem_img.delete();
    run_walk("R2 identity", 64'h12345, 1'b0, 64'h2000, 64'h10_0000, 64'h120FD, 0, 0);
    chk("R2 latency", 64'(last_lat), 64'h1);
    run_walk("R2 top of memory", 64'hF_FFFF, 1'b0, 64'h2000, 64'h10_0000, 64'hF_E0FD, 0, 0);
    run_walk("R3 at memory size", 64'h10_0000, 1'b0, 64'h2000, 64'h10_0000, 64'h0, 0, 0);
  endtask

  task automatic t_deep;
    load_tree(64'h400FD);
    run_walk("R6 page leaf", VA_DEEP, 1'b1, 64'h2000, 64'h10_0000, 64'h400FD, 3, 0);
    chk("R4 level0 address", rd_log[0], 64'h2008);
    chk("R8 level1 address", rd_log[1], 64'h4010);
    chk("R8 level2 address", rd_log[2], 64'h6018);
  endtask

  task automatic t_super;
    mem_img.delete();
    mem_img[64'h2008] = 64'h4002;
    mem_img[64'h4010] = 64'h800FD;
    run_walk("R6 mid superpage", 64'h2_0100_A010, 1'b1, 64'h2000, 64'h10_0000, 64'h8A0FD, 2, 0);
    mem_img.delete();
    mem_img[64'h2000] = 64'hFD;
    run_walk("R6 top superpage", 64'h200_6007, 1'b1, 64'h2000, 64'h400_0000, 64'h20060FD, 1, 0);
  endtask

  task automatic t_leaf_bound;
    load_tree(64'hFE0FD);
    run_walk("R7 leaf just inside", VA_DEEP, 1'b1, 64'h2000, 64'h10_0000, 64'hFE0FD, 3, 0);
    load_tree(64'h1000FD);
    run_walk("R7 leaf outside", VA_DEEP, 1'b1, 64'h2000, 64'h10_0000, 64'h0, 3, 0);
  endtask

  task automatic t_pte_bound;
    mem_img.delete();
    run_walk("R5 entry address at size", 64'h2_0000_0000, 1'b1, 64'hF_FFF8, 64'h10_0000, 64'h0, 0, 0);
    run_walk("R9 last in-range entry empty", 64'h0, 1'b1, 64'hF_FFF8, 64'h10_0000, 64'h0, 1, 0);
    chk("R5 boundary read address", rd_log[0], 64'hF_FFF8);
  endtask

  task automatic t_invalid;
    mem_img.delete();
    mem_img[64'h2008] = 64'h4002;
    mem_img[64'h4010] = 64'hFC;
    run_walk("R9 neither leaf nor table", VA_DEEP, 1'b1, 64'h2000, 64'h10_0000, 64'h0, 2, 0);
  endtask

  task automatic t_exhaust;
    load_tree(64'h8002);
    run_walk("R10 pointer at bottom", VA_DEEP, 1'b1, 64'h2000, 64'h10_0000, 64'h0, 3, 0);
  endtask

  task automatic t_sample;
    load_tree(64'h400FD);
    run_walk("R12 inputs sampled once", VA_DEEP, 1'b1, 64'h2000, 64'h10_0000, 64'h400FD, 3, 1);
  endtask

  task automatic t_stall;
    load_tree(64'h400FD);
    stall_left = 3;
    run_walk("R11 stalled reads", VA_DEEP, 1'b1, 64'h2000, 64'h10_0000, 64'h400FD, 3, 0);
    chk("R11 first held address", rd_log[0], 64'h2008);
    chk("R11 last address", rd_log[2], 64'h6018);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_vm_off();
    t_deep();
    t_super();
    t_leaf_bound();
    t_pte_bound();
    t_invalid();
    t_exhaust();
    t_sample();
    t_stall();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule